// File: doc/BRIEF.md
# I2C Register Slave with Auto-Increment

This block is an I2C target that gives a bus master access to a bank of 64 byte-wide registers. SCL and SDA are oversampled with the system clock. From those samples the block finds START, repeated START and STOP conditions and steps through the bus transfers. SDA is driven open-drain: the block only pulls the line low, through an output-enable pin.

A write transfer has three bytes in order: the device address with the write bit, a register-select byte, then data. The register-select byte sets a 6-bit pointer and turns pointer stepping on or off. With stepping off, every data byte needs a new register-select byte in front of it. With stepping on, data bytes fill consecutive registers. One index, 26, is a reload slot: when a data byte arrives while the pointer sits on it, that byte becomes the new pointer and is not stored. A read sets the pointer with a write transfer, then issues a repeated START and the device address with the read bit. The block then returns register contents until the master declines to acknowledge a byte.

Top module: `i2c_regslave`

## Requirements
- R1: A device-address byte whose upper seven bits equal the configured address (default 7'h48) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects write (0) or read (1).
- R2: A device-address byte that does not match gets no acknowledge. All later bytes get no acknowledge and have no effect until the next START or repeated START.
- R3: In the register-select byte, bits [5:0] load the pointer, bit 7 sets stepping mode (1 = on), and bit 6 is ignored. The mode is re-latched with every register-select byte. The byte is acknowledged.
- R4: With stepping off, bytes after the device address alternate between register-select and data. Each data byte is stored at the pointer and acknowledged, and the pointer is left unchanged.
- R5: With stepping on, each stored data byte advances the pointer by one, and the pointer wraps from 63 to 0.
- R6: With stepping on, a data byte that arrives while the pointer equals 26 is not stored. Its bits [5:0] become the new pointer, and the next data byte goes to that pointer.
- R7: A START, repeated START or STOP ends any transfer in progress. The first byte after a START or repeated START is always taken as a device address.
- R8: After the read device address, the block sends the register at the pointer, MSB first. On a master acknowledge it sends the next byte: from pointer+1 (wrapping 63 to 0) with stepping on, or from the same register with stepping off.
- R9: When the master does not acknowledge a read byte, the block leaves SDA released until the next START or STOP.
- R10: The SDA output enable changes only while the sampled SCL is low.
- R11: After reset SDA is released and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1; release when 0 |

## Verification
Two actions can fall on the same completed data byte: storing it into the register file and reloading the pointer from it. Both are decided in the cycle the eighth bit is sampled. The bench provokes the clash two ways: with an auto-increment burst that walks onto index 26, and with a register-select byte that points straight at 26 while stepping is on. Correct handling is judged from later reads: register 26 must keep its earlier value, and the byte after the reload must land on the reloaded index. The bench also forces a repeated START into a running burst, so that ending the transfer and the pending pointer step meet. The next byte must then be treated as a device address, not as data.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_RAB,
    ST_RAB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_PRE,
    ST_SKIP
  } rs_state_e;

endpackage

// File: rtl/i2c_rs_rstsync.sv
module i2c_rs_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_rs_sampler.sv
module i2c_rs_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_q,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sy;
  logic [SYNC_STAGES-1:0] sda_sy;
  logic                   sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sy[SYNC_STAGES-1];
      sda_q  <= sda_sy[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sy[SYNC_STAGES-1];
  assign sda_s     = sda_sy[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile #(
  parameter int NREG = 64,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ent [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic          hit;
    logic [DW-1:0] val_q;

    assign hit = we && (waddr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wdata;
      end
    end

    assign ent[g] = val_q;
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h48,
  parameter int         PTR_W      = 6,
  parameter int         RELOAD_IDX = 26,
  localparam int        BYTE_W     = 8,
  localparam int        CNT_W      = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [PTR_W-1:0]  rf_raddr,
  output logic              rf_we,
  output logic [PTR_W-1:0]  rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              sda_oe,
  output rs_state_e         state_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              ainc_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [PTR_W-1:0] RELOAD   = PTR_W'(RELOAD_IDX);

  rs_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              ainc_q, ainc_n;
  logic              half_q, half_n;
  logic              oe_q, oe_n;
  logic [BYTE_W-1:0] rx_byte;
  logic [PTR_W-1:0]  ptr_inc;
  logic              we_c;

  assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};
  assign ptr_inc = ptr_q + 1'b1;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    ptr_n  = ptr_q;
    ainc_n = ainc_q;
    half_n = half_q;
    oe_n   = oe_q;
    we_c   = 1'b0;
    if (stop_det) begin
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      half_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_DEV;
      cnt_n  = '0;
      oe_n   = 1'b0;
      half_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_RAB, ST_WR: begin
          if (scl_rise) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              half_n = 1'b0;
              if (st_q == ST_DEV) begin
                st_n = (rx_byte[BYTE_W-1:1] == DEV_ADDR) ? ST_DEV_ACK : ST_SKIP;
              end else if (st_q == ST_RAB) begin
                ptr_n  = rx_byte[PTR_W-1:0];
                ainc_n = rx_byte[BYTE_W-1];
                st_n   = ST_RAB_ACK;
              end else begin
                if (ainc_q && (ptr_q == RELOAD)) begin
                  ptr_n = rx_byte[PTR_W-1:0];
                end else begin
                  we_c = 1'b1;
                  if (ainc_q) begin
                    ptr_n = ptr_inc;
                  end
                end
                st_n = ST_WR_ACK;
              end
            end
          end
        end
        ST_DEV_ACK, ST_RAB_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!half_q) begin
              half_n = 1'b1;
              oe_n   = 1'b1;
            end else begin
              half_n = 1'b0;
              cnt_n  = '0;
              oe_n   = 1'b0;
              if (st_q == ST_DEV_ACK) begin
                if (sh_q[0]) begin
                  st_n = ST_TX;
                  tx_n = rf_rdata;
                  oe_n = ~rf_rdata[BYTE_W-1];
                end else begin
                  st_n = ST_RAB;
                end
              end else if (st_q == ST_RAB_ACK) begin
                st_n = ST_WR;
              end else begin
                st_n = ainc_q ? ST_WR : ST_RAB;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              st_n   = ST_TX_ACK;
              half_n = 1'b0;
            end
          end else if (scl_fall) begin
            tx_n = {tx_q[BYTE_W-2:0], 1'b0};
            oe_n = ~tx_q[BYTE_W-2];
          end
        end
        ST_TX_ACK: begin
          if (scl_fall && !half_q) begin
            oe_n   = 1'b0;
            half_n = 1'b1;
          end else if (scl_rise && half_q) begin
            half_n = 1'b0;
            if (sda_s) begin
              st_n = ST_SKIP;
            end else begin
              if (ainc_q) begin
                ptr_n = ptr_inc;
              end
              st_n = ST_TX_PRE;
            end
          end
        end
        ST_TX_PRE: begin
          if (scl_fall) begin
            tx_n  = rf_rdata;
            oe_n  = ~rf_rdata[BYTE_W-1];
            cnt_n = '0;
            st_n  = ST_TX;
          end
        end
        default: begin
          oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      ainc_q <= 1'b0;
      half_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      ptr_q  <= ptr_n;
      ainc_q <= ainc_n;
      half_q <= half_n;
      oe_q   <= oe_n;
    end
  end

  assign rf_raddr = ptr_q;
  assign rf_we    = we_c;
  assign rf_waddr = ptr_q;
  assign rf_wdata = rx_byte;
  assign sda_oe   = oe_q;
  assign state_o  = st_q;
  assign ptr_o    = ptr_q;
  assign ainc_o   = ainc_q;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         NREG        = 64,
  parameter int         RELOAD_IDX  = 26,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NREG),
  localparam int        DW          = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  logic             rst_ns;
  logic             scl_s, scl_q, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0]    rf_rdata, rf_wdata;
  logic [PTR_W-1:0] rf_raddr, rf_waddr, ptr;
  logic             rf_we, sda_oe, ainc;
  rs_state_e        state;

  i2c_rs_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  i2c_rs_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .scl_q     (scl_q),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rs_engine #(
    .DEV_ADDR   (DEV_ADDR),
    .PTR_W      (PTR_W),
    .RELOAD_IDX (RELOAD_IDX)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .rf_rdata  (rf_rdata),
    .rf_raddr  (rf_raddr),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .sda_oe    (sda_oe),
    .state_o   (state),
    .ptr_o     (ptr),
    .ainc_o    (ainc)
  );

  i2c_rs_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign sda_oe_o = sda_oe;

endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker
  import i2c_rs_pkg::*;
#(
  parameter int PTR_W      = 6,
  parameter int RELOAD_IDX = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             scl_q,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input rs_state_e        state,
  input logic             ainc,
  input logic [PTR_W-1:0] ptr,
  input logic             rf_we
);

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |=> $stable(sda_oe)); // R10

  AST_QUIET_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe); // R9

  AST_RELOAD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !(ainc && ptr == PTR_W'(RELOAD_IDX))); // R6

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && !sda_oe)); // R7

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe)); // R7

endmodule

bind i2c_regslave i2c_rs_checker #(
  .PTR_W      (PTR_W),
  .RELOAD_IDX (RELOAD_IDX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .scl_s     (scl_s),
  .scl_q     (scl_q),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .state     (state),
  .ainc      (ainc),
  .ptr       (ptr),
  .rf_we     (rf_we)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;

  localparam int         Q    = 6;
  localparam logic [6:0] DEVA = 7'h48;
  localparam logic [7:0] DW_B = {DEVA, 1'b0};
  localparam logic [7:0] DR_B = {DEVA, 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_regslave u_i2c_regslave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [64];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wt();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(); scl_m = 1'b1; wt(); wt(); scl_m = 1'b0; wt();
    end
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); ack = sda_bus; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(); scl_m = 1'b1; wt(); b = {b[6:0], sda_bus}; wt(); scl_m = 1'b0;
    end
    wt(); sda_m = nack; wt(); scl_m = 1'b1; wt(); wt(); scl_m = 1'b0; wt(); sda_m = 1'b1;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [7:0] d);
    logic k;
    i2c_start(); send_byte(DW_B, k); send_byte({2'b00, a}, k);
    i2c_start(); send_byte(DR_B, k); recv_byte(1'b1, d); i2c_stop();
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 73 + 11) & 255);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       k;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: released bus and zeroed registers after reset
    chk("R11 oe after reset", {7'd0, sda_oe}, 8'h00);
    rd_reg(6'd0, d);  chk("R11 reg0", d, 8'h00);
    rd_reg(6'd63, d); chk("R11 reg63", d, 8'h00);

    // R1 R3 R4: alternating select/data sweep over every register, bit 6 set on odd indices
    i2c_start();
    send_byte(DW_B, k); chk("R1 write address ack", {7'd0, k}, 8'h00);
    for (int i = 0; i < 64; i++) begin
      send_byte(8'(i) | ((i % 2 == 1) ? 8'h40 : 8'h00), k);
      if (i < 2) chk("R3 select ack", {7'd0, k}, 8'h00);
      send_byte(pat(i), k);
      if (i < 2) chk("R4 data ack", {7'd0, k}, 8'h00);
      shadow[i] = pat(i);
    end
    i2c_stop();
    for (int i = 0; i < 64; i += 4) begin
      rd_reg(6'(i), d); chk("R4 single read", d, shadow[i]);
    end

    // R8: stepping read over all registers plus one wrap byte
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80, k);
    i2c_start(); send_byte(DR_B, k); chk("R1 read address ack", {7'd0, k}, 8'h00);
    for (int i = 0; i < 65; i++) begin
      recv_byte(i == 64, d);
      chk("R8 stepping read", d, shadow[i % 64]);
    end
    wt();
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    wt();
    chk("R9 bus high after nack", {7'd0, sda_bus}, 8'h01);
    i2c_stop();

    // R8: stepping off, acked read repeats the same register
    i2c_start(); send_byte(DW_B, k); send_byte(8'd7, k);
    i2c_start(); send_byte(DR_B, k);
    recv_byte(1'b0, d); chk("R8 hold first", d, shadow[7]);
    recv_byte(1'b1, d); chk("R8 hold repeat", d, shadow[7]);
    i2c_stop();

    // R6: burst walks onto index 26; byte there reloads pointer to 40 (upper bits ignored)
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80 | 8'd22, k);
    for (int i = 22; i < 26; i++) begin
      send_byte(8'hA0 + 8'(i), k); shadow[i] = 8'hA0 + 8'(i);
    end
    send_byte(8'hE8, k); chk("R6 reload ack", {7'd0, k}, 8'h00);
    send_byte(8'h3C, k); shadow[40] = 8'h3C;
    send_byte(8'h3D, k); shadow[41] = 8'h3D;
    i2c_stop();
    rd_reg(6'd25, d); chk("R5 burst last before slot", d, shadow[25]);
    rd_reg(6'd26, d); chk("R6 slot not stored", d, shadow[26]);
    rd_reg(6'd27, d); chk("R6 after slot untouched", d, shadow[27]);
    rd_reg(6'd40, d); chk("R6 reloaded target", d, shadow[40]);
    rd_reg(6'd41, d); chk("R6 reloaded next", d, shadow[41]);

    // R6: select byte points straight at 26 with stepping on
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80 | 8'd26, k);
    send_byte(8'h05, k);
    send_byte(8'h77, k); shadow[5] = 8'h77;
    i2c_stop();
    rd_reg(6'd26, d); chk("R6 direct slot kept", d, shadow[26]);
    rd_reg(6'd5, d);  chk("R6 direct reload target", d, shadow[5]);

    // R5: stepping write wraps 63 -> 0
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80 | 8'd62, k);
    send_byte(8'hC0, k); shadow[62] = 8'hC0;
    send_byte(8'hC1, k); shadow[63] = 8'hC1;
    send_byte(8'hC2, k); shadow[0]  = 8'hC2;
    i2c_stop();
    rd_reg(6'd62, d); chk("R5 wrap 62", d, shadow[62]);
    rd_reg(6'd63, d); chk("R5 wrap 63", d, shadow[63]);
    rd_reg(6'd0, d);  chk("R5 wrap 0", d, shadow[0]);

    // R7: repeated START ends burst; next byte is device address then select
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80 | 8'd10, k);
    send_byte(8'h11, k); shadow[10] = 8'h11;
    send_byte(8'h12, k); shadow[11] = 8'h12;
    i2c_start(); send_byte(DW_B, k); chk("R7 address after restart", {7'd0, k}, 8'h00);
    send_byte(8'd12, k); send_byte(8'h5A, k); shadow[12] = 8'h5A;
    send_byte(8'd14, k); send_byte(8'h6B, k); shadow[14] = 8'h6B;
    i2c_stop();
    rd_reg(6'd11, d); chk("R7 burst before restart", d, shadow[11]);
    rd_reg(6'd12, d); chk("R7 select after restart", d, shadow[12]);
    rd_reg(6'd13, d); chk("R4 skipped register", d, shadow[13]);
    rd_reg(6'd14, d); chk("R4 second select", d, shadow[14]);

    // R7: STOP ends burst
    i2c_start(); send_byte(DW_B, k); send_byte(8'h80 | 8'd30, k);
    send_byte(8'h21, k); shadow[30] = 8'h21;
    i2c_stop();
    i2c_start(); send_byte(DW_B, k); send_byte(8'd33, k); send_byte(8'h44, k); shadow[33] = 8'h44;
    i2c_stop();
    rd_reg(6'd31, d); chk("R7 stop ended burst", d, shadow[31]);
    rd_reg(6'd33, d); chk("R7 new select after stop", d, shadow[33]);

    // R2: wrong address is ignored until the next START
    i2c_start();
    send_byte({DEVA ^ 7'h01, 1'b0}, k); chk("R2 no ack wrong address", {7'd0, k}, 8'h01);
    send_byte(8'd3, k);  chk("R2 no ack select", {7'd0, k}, 8'h01);
    send_byte(8'h99, k); chk("R2 no ack data", {7'd0, k}, 8'h01);
    i2c_start();
    send_byte(DW_B, k);  chk("R2 recovers at restart", {7'd0, k}, 8'h00);
    i2c_stop();
    rd_reg(6'd3, d); chk("R2 register untouched", d, shadow[3]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule